// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block sits on the command side of a page-programmable nonvolatile memory controller. It watches the stream of latched bus write cycles. Each write carries an address and a data byte and is marked by a one-cycle strobe. The block recognises the multi-cycle unlock prefixes that guard every data-altering operation. It turns a completed prefix into a single-cycle command pulse for the rest of the controller: protected page write, chip erase, protection disable, identification entry or identification exit.

Every prefix starts with the same two cycles. The third cycle either selects a short command or opens a six-cycle form that repeats the two opening cycles before a final selector. The block also keeps the whole-array write-protection flag.

- When protection is off, a bare write is handed straight to the page buffer as a load byte.
- When protection is on, a bare write changes nothing. It starts a lockout window of programmable length instead, and writes arriving during that window are dropped.
- After the enable-and-write command, every following write is a load byte until the controller's internal write cycle begins.

Top module: `cmd_unlock_decoder`

## Requirements
- R1: After reset the protection flag, the lockout indication, every command pulse and the load strobe are all low.
- R2: The three-cycle commands take data AAh at address 5555h, then 55h at 2AAAh, then a selector at 5555h. The selector A0h gives a page-write pulse, 90h gives an ID-entry pulse and F0h gives an ID-exit pulse. Each pulse appears in the cycle after the last write.
- R3: A selector of 80h opens the six-cycle form, which continues with AAh at 5555h and 55h at 2AAAh. A final byte at 5555h then selects the command: 10h gives a chip-erase pulse, 20h gives a protection-disable pulse and 60h gives an ID-entry pulse.
- R4: Only address bits 14..0 take part in matching; bits above 14 may hold any value.
- R5: The protection flag is set in the same cycle as the page-write pulse. It is cleared only together with the protection-disable pulse, and no other command changes it.
- R6: While protection is off, a write that does not start or continue a prefix produces a load strobe one cycle later, carrying that write's full address and data.
- R7: While protection is on, such a write produces no load strobe. It raises the lockout indication for exactly LOCK_CYCLES cycles, starting the next cycle, and all writes during the lockout are ignored.
- R8: A write that breaks a prefix returns the decoder to idle and is then judged as if it were the first write. AAh at 5555h therefore restarts the prefix, and any other value follows R6 or R7.
- R9: After the page-write command, every write, including AAh at 5555h, is a load strobe. This continues until the internal write-busy input is seen high, which returns the decoder to idle.
- R10: Writes presented while the internal write-busy input is high produce no pulse and no load strobe.
- R11: Command pulses last one cycle and at most one is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | One-cycle strobe of a latched bus write |
| wr_addr | input | ADDR_W | Latched write address |
| wr_data | input | 8 | Latched write data |
| array_busy | input | 1 | Internal write or erase cycle in progress |
| cmd_page_write | output | 1 | Pulse: protected page write opened |
| cmd_chip_erase | output | 1 | Pulse: chip erase requested |
| cmd_prot_disable | output | 1 | Pulse: protection turned off |
| cmd_id_entry | output | 1 | Pulse: enter identification mode |
| cmd_id_exit | output | 1 | Pulse: leave identification mode |
| load_valid | output | 1 | Load byte strobe toward the page buffer |
| load_addr | output | ADDR_W | Address of the load byte |
| load_data | output | 8 | Data of the load byte |
| prot_enabled | output | 1 | Whole-array write protection active |
| lockout_busy | output | 1 | Lockout window after a rejected write |

## Verification
A decoder left in the wrong prefix state shows up on the very next write. Either a command pulse fires one cycle after a selector byte that should have been a load byte, or an expected pulse or load strobe is missing in that cycle. A stale protection flag appears one cycle after a bare write: it produces a load strobe where a lockout was due, or the reverse. The bench therefore compares pulses and load strobes every cycle against a queue of expected results, and it times the lockout width edge to edge.

// File: rtl/cud_pkg.sv
package cud_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_P1, ST_P2, ST_X3, ST_X4, ST_X5, ST_OPEN
  } seq_state_t;

  typedef enum logic [3:0] {
    K_OTHER, K_LEAD, K_SECOND, K_PGW, K_IDIN, K_IDOUT,
    K_EXT, K_ERASE, K_UNPROT, K_IDALT
  } step_kind_t;

  localparam int CMP_W = 15;
  localparam logic [CMP_W-1:0] ADR_A = 15'h5555;
  localparam logic [CMP_W-1:0] ADR_B = 15'h2AAA;

  // Classifies one write cycle by its compared address bits and data.
  function automatic step_kind_t classify(input logic [CMP_W-1:0] a,
                                          input logic [7:0] d);
    step_kind_t k;
    k = K_OTHER;
    if (a == ADR_B) begin
      if (d == 8'h55) k = K_SECOND;
    end else if (a == ADR_A) begin
      case (d)
        8'hAA:   k = K_LEAD;
        8'hA0:   k = K_PGW;
        8'h90:   k = K_IDIN;
        8'hF0:   k = K_IDOUT;
        8'h80:   k = K_EXT;
        8'h10:   k = K_ERASE;
        8'h20:   k = K_UNPROT;
        8'h60:   k = K_IDALT;
        default: k = K_OTHER;
      endcase
    end
    return k;
  endfunction

endpackage

// File: rtl/cud_step_match.sv
module cud_step_match
  import cud_pkg::*;
(
  input  logic [CMP_W-1:0] addr_lo,
  input  logic [7:0]       data,
  output step_kind_t       kind
);
  assign kind = classify(addr_lo, data);
endmodule

// File: rtl/cud_lockout.sv
module cud_lockout #(
  parameter int LOCK_CYCLES = 37500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(LOCK_CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (start)      cnt_q <= CW'(LOCK_CYCLES);
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

  assert_lock_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  assert_lock_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy);
endmodule

// File: rtl/cud_seq_fsm.sv
module cud_seq_fsm
  import cud_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              array_busy,
  input  step_kind_t        kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  output logic              cmd_page_write,
  output logic              cmd_chip_erase,
  output logic              cmd_prot_disable,
  output logic              cmd_id_entry,
  output logic              cmd_id_exit,
  output logic              load_valid,
  output logic [ADDR_W-1:0] load_addr,
  output logic [7:0]        load_data,
  output logic              prot_enabled,
  output logic              lock_start
);
  seq_state_t st_q, st_d;
  logic prot_q;
  logic ev_pgw, ev_erase, ev_unprot, ev_ide, ev_idx, ev_load, ev_lock, fresh;

  always_comb begin
    st_d = st_q;
    ev_pgw = 1'b0; ev_erase = 1'b0; ev_unprot = 1'b0;
    ev_ide = 1'b0; ev_idx = 1'b0; ev_load = 1'b0; ev_lock = 1'b0;
    fresh = 1'b0;
    if (st_q == ST_OPEN && array_busy) begin
      st_d = ST_IDLE;
    end else if (accept) begin
      case (st_q)
        ST_IDLE: fresh = 1'b1;
        ST_P1:   if (kind == K_SECOND) st_d = ST_P2; else fresh = 1'b1;
        ST_P2: begin
          case (kind)
            K_PGW:   begin st_d = ST_OPEN; ev_pgw = 1'b1; end
            K_IDIN:  begin st_d = ST_IDLE; ev_ide = 1'b1; end
            K_IDOUT: begin st_d = ST_IDLE; ev_idx = 1'b1; end
            K_EXT:   st_d = ST_X3;
            default: fresh = 1'b1;
          endcase
        end
        ST_X3:   if (kind == K_LEAD)   st_d = ST_X4; else fresh = 1'b1;
        ST_X4:   if (kind == K_SECOND) st_d = ST_X5; else fresh = 1'b1;
        ST_X5: begin
          st_d = ST_IDLE;
          case (kind)
            K_ERASE:  ev_erase  = 1'b1;
            K_UNPROT: ev_unprot = 1'b1;
            K_IDALT:  ev_ide    = 1'b1;
            default:  fresh     = 1'b1;
          endcase
        end
        ST_OPEN: ev_load = 1'b1;
        default: st_d = ST_IDLE;
      endcase
      if (fresh) begin
        if (kind == K_LEAD) begin
          st_d = ST_P1;
        end else begin
          st_d = ST_IDLE;
          if (prot_q) ev_lock = 1'b1;
          else        ev_load = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q             <= ST_IDLE;
      prot_q           <= 1'b0;
      cmd_page_write   <= 1'b0;
      cmd_chip_erase   <= 1'b0;
      cmd_prot_disable <= 1'b0;
      cmd_id_entry     <= 1'b0;
      cmd_id_exit      <= 1'b0;
      load_valid       <= 1'b0;
      load_addr        <= '0;
      load_data        <= '0;
    end else begin
      st_q             <= st_d;
      cmd_page_write   <= ev_pgw;
      cmd_chip_erase   <= ev_erase;
      cmd_prot_disable <= ev_unprot;
      cmd_id_entry     <= ev_ide;
      cmd_id_exit      <= ev_idx;
      load_valid       <= ev_load;
      if (ev_load) begin
        load_addr <= addr;
        load_data <= data;
      end
      if (ev_pgw)         prot_q <= 1'b1;
      else if (ev_unprot) prot_q <= 1'b0;
    end
  end

  assign prot_enabled = prot_q;
  assign lock_start   = ev_lock;

  logic [4:0] pulses;
  assign pulses = {cmd_page_write, cmd_chip_erase, cmd_prot_disable,
                   cmd_id_entry, cmd_id_exit};

  assert_onehot_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pulses));
  assert_single_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|pulses) |=> !(|pulses));
  assert_prot_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prot_q) |-> cmd_page_write);
  assert_prot_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prot_q) |-> cmd_prot_disable);
  assert_busy_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    array_busy |=> !(|pulses) && !load_valid);
  assert_lock_no_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_start |=> !load_valid && prot_q);
endmodule

// File: rtl/cmd_unlock_decoder.sv
module cmd_unlock_decoder
  import cud_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int LOCK_CYCLES = 37500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              array_busy,
  output logic              cmd_page_write,
  output logic              cmd_chip_erase,
  output logic              cmd_prot_disable,
  output logic              cmd_id_entry,
  output logic              cmd_id_exit,
  output logic              load_valid,
  output logic [ADDR_W-1:0] load_addr,
  output logic [7:0]        load_data,
  output logic              prot_enabled,
  output logic              lockout_busy
);
  step_kind_t kind;
  logic       accept;
  logic       lock_start;

  cud_step_match u_match (
    .addr_lo (wr_addr[CMP_W-1:0]),
    .data    (wr_data),
    .kind    (kind)
  );

  assign accept = wr_valid && !array_busy && !lockout_busy;

  cud_seq_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk              (clk),
    .rst_n            (rst_n),
    .accept           (accept),
    .array_busy       (array_busy),
    .kind             (kind),
    .addr             (wr_addr),
    .data             (wr_data),
    .cmd_page_write   (cmd_page_write),
    .cmd_chip_erase   (cmd_chip_erase),
    .cmd_prot_disable (cmd_prot_disable),
    .cmd_id_entry     (cmd_id_entry),
    .cmd_id_exit      (cmd_id_exit),
    .load_valid       (load_valid),
    .load_addr        (load_addr),
    .load_data        (load_data),
    .prot_enabled     (prot_enabled),
    .lock_start       (lock_start)
  );

  cud_lockout #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk   (clk),
    .rst_n (rst_n),
    .start (lock_start),
    .busy  (lockout_busy)
  );

  assert_lock_ignores_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lockout_busy && wr_valid) |=> !load_valid && !(cmd_page_write ||
      cmd_chip_erase || cmd_prot_disable || cmd_id_entry || cmd_id_exit));
endmodule

// File: tb/cmd_unlock_decoder_tb.sv
`timescale 1ns/1ps
module cmd_unlock_decoder_tb;
  localparam int AW = 17;
  localparam int LC = 12;
  localparam int C_NONE = 0, C_LOAD = 1, C_PGW = 2, C_ERASE = 3,
                 C_UNPROT = 4, C_IDE = 5, C_IDX = 6, C_MULTI = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, array_busy = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic cmd_page_write, cmd_chip_erase, cmd_prot_disable, cmd_id_entry, cmd_id_exit;
  logic load_valid, prot_enabled, lockout_busy;
  logic [AW-1:0] load_addr;
  logic [7:0] load_data;

  int checks = 0, errors = 0;
  bit mon_on = 1'b0;

  int          q_code[$];
  logic [AW-1:0] q_addr[$];
  logic [7:0]  q_data[$];
  string       q_tag[$];

  always #4 clk = ~clk;

  cmd_unlock_decoder #(.ADDR_W(AW), .LOCK_CYCLES(LC)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .array_busy(array_busy),
    .cmd_page_write(cmd_page_write), .cmd_chip_erase(cmd_chip_erase),
    .cmd_prot_disable(cmd_prot_disable), .cmd_id_entry(cmd_id_entry),
    .cmd_id_exit(cmd_id_exit), .load_valid(load_valid), .load_addr(load_addr),
    .load_data(load_data), .prot_enabled(prot_enabled), .lockout_busy(lockout_busy)
  );

  function automatic int out_code();
    int n;
    int c;
    n = int'(cmd_page_write) + int'(cmd_chip_erase) + int'(cmd_prot_disable) +
        int'(cmd_id_entry) + int'(cmd_id_exit) + int'(load_valid);
    c = C_NONE;
    if (n > 1) c = C_MULTI;
    else if (load_valid)       c = C_LOAD;
    else if (cmd_page_write)   c = C_PGW;
    else if (cmd_chip_erase)   c = C_ERASE;
    else if (cmd_prot_disable) c = C_UNPROT;
    else if (cmd_id_entry)     c = C_IDE;
    else if (cmd_id_exit)      c = C_IDX;
    return c;
  endfunction

  task automatic check_bit(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  // Driver: one write cycle, expected outcome pushed to the scoreboard.
  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d,
                    input int code, input string tag);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    q_code.push_back(code); q_addr.push_back(a);
    q_data.push_back(d);   q_tag.push_back(tag);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  // Monitor: compares outputs after every edge with the scoreboard.
  always @(posedge clk) begin
    #2;
    if (mon_on) begin
      if (q_code.size() > 0) begin
        int c;
        logic [AW-1:0] a;
        logic [7:0] d;
        string t;
        c = q_code.pop_front(); a = q_addr.pop_front();
        d = q_data.pop_front(); t = q_tag.pop_front();
        checks++;
        if (out_code() != c ||
            (c == C_LOAD && (load_addr !== a || load_data !== d))) begin
          errors++;
          $display("FAIL %s: actual code %0d addr %h data %h expected code %0d addr %h data %h",
                   t, out_code(), load_addr, load_data, c, a, d);
        end
      end else if (out_code() != C_NONE) begin
        checks++; errors++;
        $display("FAIL R11 quiet cycle: actual code %0d expected %0d", out_code(), C_NONE);
      end
    end
  end

  task automatic wait_lock_clear();
    while (lockout_busy) @(negedge clk);
  endtask

  task automatic prefix(input logic [AW-1:0] hi, input string tag);
    wr(hi | 17'h05555, 8'hAA, C_NONE, tag);
    wr(hi | 17'h02AAA, 8'h55, C_NONE, tag);
  endtask

  task automatic six(input logic [7:0] sel, input int code, input string tag);
    prefix('0, tag);
    wr(17'h05555, 8'h80, C_NONE, tag);
    prefix('0, tag);
    wr(17'h05555, sel, code, tag);
  endtask

  initial begin
    #(8 * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check_bit(prot_enabled, 1'b0, "R1 prot after reset");
    check_bit(lockout_busy, 1'b0, "R1 lockout after reset");
    check_bit(load_valid | cmd_page_write | cmd_id_entry, 1'b0, "R1 outputs after reset");
    rst_n = 1'b1;
    mon_on = 1'b1;
    @(negedge clk);

    // R6 unprotected plain write passes through
    wr(17'h12345, 8'h3C, C_LOAD, "R6 plain load");
    // R4 upper address bits ignored, R2 ID entry
    prefix(17'h18000, "R4 high bits prefix");
    wr(17'h1D555, 8'h90, C_IDE, "R4 R2 id entry high bits");
    // R2 ID exit
    prefix('0, "R2 prefix");
    wr(17'h05555, 8'hF0, C_IDX, "R2 id exit");
    // R8 restart on repeated lead cycle
    wr(17'h05555, 8'hAA, C_NONE, "R8 lead");
    prefix('0, "R8 restart");
    wr(17'h05555, 8'hF0, C_IDX, "R8 restart id exit");
    // R8 broken prefix judged fresh: load byte
    wr(17'h05555, 8'hAA, C_NONE, "R8 lead");
    wr(17'h00100, 8'h77, C_LOAD, "R8 break becomes load");
    // R8 unknown selector becomes load
    prefix('0, "R8 prefix");
    wr(17'h05555, 8'h33, C_LOAD, "R8 unknown selector load");
    // R3 alternate ID entry
    six(8'h60, C_IDE, "R3 alt id entry");
    check_bit(prot_enabled, 1'b0, "R5 prot still off");

    // R2 R5 page write sets protection
    prefix('0, "R2 pgw prefix");
    wr(17'h05555, 8'hA0, C_PGW, "R2 page write");
    check_bit(prot_enabled, 1'b1, "R5 prot set by page write");
    // R9 page load bytes
    wr(17'h00080, 8'h11, C_LOAD, "R9 load 0");
    wr(17'h00081, 8'h22, C_LOAD, "R9 load 1");
    wr(17'h05555, 8'hAA, C_LOAD, "R9 lead as data");
    // R10 ignored while busy
    @(negedge clk); array_busy = 1'b1;
    wr(17'h00082, 8'h44, C_NONE, "R10 write during busy");
    @(negedge clk); array_busy = 1'b0;

    // R7 protected plain write: lockout width
    wr(17'h00300, 8'h55, C_NONE, "R7 rejected write");
    begin
      int n;
      n = 0;
      check_bit(lockout_busy, 1'b1, "R7 lockout raised");
      while (lockout_busy && n < 100) begin @(negedge clk); n++; end
      checks++;
      if (n != LC) begin
        errors++;
        $display("FAIL R7 lockout width: actual %0d expected %0d", n, LC);
      end
    end

    // R3 chip erase, R5 protection unchanged
    six(8'h10, C_ERASE, "R3 chip erase");
    check_bit(prot_enabled, 1'b1, "R5 prot kept after erase");

    // R7 writes during lockout ignored
    wr(17'h00400, 8'h66, C_NONE, "R7 rejected write 2");
    prefix('0, "R7 ignored prefix");
    wr(17'h05555, 8'h90, C_NONE, "R7 ignored selector");
    wait_lock_clear();
    wr(17'h05555, 8'h90, C_NONE, "R7 lone selector no id");
    check_bit(lockout_busy, 1'b1, "R7 lone selector locks");
    wait_lock_clear();

    // R3 R5 disable protection
    six(8'h20, C_UNPROT, "R3 prot disable");
    check_bit(prot_enabled, 1'b0, "R5 prot cleared by disable");
    wr(17'h1FFFF, 8'h9A, C_LOAD, "R6 load after disable");
    check_bit(lockout_busy, 1'b0, "R6 no lockout when off");

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule